// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block is the register face of a sixteen-channel DMA controller. A host drives a small register bus (window select, byte address, write data, write and read strobes). The block turns each 32-bit access into a hit on one channel's control/status word, descriptor pointer or debug word, or on one of two global registers: the per-channel interrupt summary and the channel enable mask. It does not move data. The transfer engines sit beside it. They take from it a one-cycle start pulse, the descriptor pointer and the enable mask. They give back the fields of the descriptor they are working on, three live status flags and a completion event that may carry an interrupt request.

Fifteen channels share the main window with the global registers. The last channel has an identical map in a second window of its own. The control/status word holds three kinds of bit. Plain read/write bits are stored through a fixed mask. The completion and interrupt flags are cleared by writing one to them. The abort and reset request bits are write-only and drop back to zero on their own. Each channel drives its own interrupt line, and that line follows its interrupt flag.

Top module: `dmareg_front`

## Requirements
- R1: After reset the enable mask reads 0x0000FFFF, the interrupt summary reads 0, every channel's control/status word and descriptor pointer read 0, and all interrupt lines are low.
- R2: In the main window (window select 0) a word-aligned offset below 0xF00 addresses channel offset[11:8] and register offset[7:0]. With window select 1 only offset[7:0] is used and it addresses the last channel with the same register map.
- R3: A write to control/status (register 0x00) stores exactly the write-data bits in mask 0x30FF0001 (bit 0 is ACTIVE). The mask's other bits read back as written and all other stored bits read back as 0.
- R4: Writing 1 to bit 1 (END) clears it. Writing 1 to bit 2 (INT) clears it, clears that channel's bit in the interrupt summary and drops the channel's interrupt line. Writing 0 to either bit leaves it as it was.
- R5: Bit 30 (abort request) and bit 31 (reset request) are write-only. Each reads as 1 only on a read issued in the cycle right after the write that set it, and as 0 after that.
- R6: A control/status write with bit 0 set, to a channel whose ACTIVE bit is 0, raises that channel's ch_start for exactly the one cycle after the write. A write to a channel that is already active raises no start.
- R7: An eng_done pulse clears the channel's ACTIVE bit and sets END. If eng_irq_req is high with it, the pulse also sets INT, raises irq for that channel and sets the channel's bit in the interrupt summary.
- R8: Control/status bits 4, 5 and 8 show the live eng_paused, eng_held and eng_err inputs of that channel.
- R9: Register 0x04 (descriptor pointer, also driven on ch_cba) and register 0x20 (debug) are read/write. Registers 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return the engine's info, source, destination, length, stride and next-descriptor inputs, and writes to them have no effect.
- R10: Offset 0xFE0 of the main window reads the interrupt summary, bit n being channel n's INT flag. Writes to it have no effect.
- R11: Offset 0xFF0 of the main window is the enable mask. A write stores the low 16 bits of write data, which appear on ch_en, and a read returns them zero-extended.
- R12: Reads of unmapped or misaligned offsets return 0, and writes to them change no register.
- R13: bus_rdata takes the addressed value on the clock edge where bus_rd is sampled high. It holds that value until the next read, whatever writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_win | input | 1 | Window select: 0 main window, 1 last-channel window |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_info | input | 16x32 | Per-channel shadow of the descriptor info word |
| eng_src | input | 16x32 | Per-channel shadow of the source address |
| eng_dst | input | 16x32 | Per-channel shadow of the destination address |
| eng_len | input | 16x32 | Per-channel shadow of the remaining length |
| eng_stride | input | 16x32 | Per-channel shadow of the stride word |
| eng_next | input | 16x32 | Per-channel shadow of the next-descriptor pointer |
| eng_paused | input | 16 | Per-channel paused flag |
| eng_held | input | 16 | Per-channel flow-control hold flag |
| eng_err | input | 16 | Per-channel error flag |
| eng_done | input | 16 | Per-channel completion pulse |
| eng_irq_req | input | 16 | Completion carries an interrupt request |
| ch_start | output | 16 | One-cycle start pulse per channel |
| ch_en | output | 16 | Channel enable mask |
| ch_cba | output | 16x32 | Per-channel descriptor pointer |
| irq | output | 16 | Per-channel interrupt line |

## Verification
The bench first goes after the mixed-semantics control/status word. If the writable mask were wrong, bits 16–23 or 28–29 would read back wrong, or the flag bits would get stored. A write that treated END or INT as plain data would wipe flags it should keep, or keep flags it should wipe. A reset or abort bit that did not clear itself would still read 1 on the second read. For the start logic it checks both the idle-to-active write and the write to an already active channel, so a level-triggered start would show up as a second pulse. Address decode is swept across every channel in both windows, so a design that dropped the last channel into the main window, or that let writes reach the read-only shadow, summary or unmapped offsets, would show changed values on the read that follows.

// File: rtl/dmareg_pkg.sv
`timescale 1ns/1ps
package dmareg_pkg;

    localparam int WORD_W = 32;

    // Bits of write data that land directly in the control/status word
    localparam logic [WORD_W-1:0] CS_WMASK = 32'h30FF_0001;

    // Control/status bit positions
    localparam int CSB_ACTIVE = 0;
    localparam int CSB_END    = 1;
    localparam int CSB_INT    = 2;
    localparam int CSB_PAUSE  = 4;
    localparam int CSB_HELD   = 5;
    localparam int CSB_ERR    = 8;
    localparam int CSB_ABORT  = 30;
    localparam int CSB_RESET  = 31;

    // Main-window global area
    localparam logic [11:0] OFS_GLOBAL = 12'hF00;
    localparam logic [11:0] OFS_ISUM   = 12'hFE0;
    localparam logic [11:0] OFS_ENMASK = 12'hFF0;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_CS,
        RK_CBA,
        RK_INFO,
        RK_SRC,
        RK_DST,
        RK_LEN,
        RK_STRIDE,
        RK_NEXT,
        RK_DBG,
        RK_ISUM,
        RK_ENMASK
    } reg_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] cba;
        logic [WORD_W-1:0] dbg;
        logic              end_f;
        logic              int_f;
        logic              abt;
        logic              rst;
        logic              start;
    } chan_state_t;

    function automatic reg_kind_e chan_kind(input logic [7:0] off);
        case (off)
            8'h00:   return RK_CS;
            8'h04:   return RK_CBA;
            8'h08:   return RK_INFO;
            8'h0C:   return RK_SRC;
            8'h10:   return RK_DST;
            8'h14:   return RK_LEN;
            8'h18:   return RK_STRIDE;
            8'h1C:   return RK_NEXT;
            8'h20:   return RK_DBG;
            default: return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
`timescale 1ns/1ps
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CHW = $clog2(NUM_CH)
) (
    input  logic            win,
    input  logic [11:0]     addr,
    output logic [CHW-1:0]  ch,
    output reg_kind_e       kind
);

    always_comb begin
        ch   = '0;
        kind = RK_NONE;
        if (addr[1:0] == 2'b00) begin
            if (win) begin
                ch   = CHW'(NUM_CH - 1);
                kind = chan_kind(addr[7:0]);
            end else if (addr < OFS_GLOBAL) begin
                ch   = addr[8 +: CHW];
                kind = chan_kind(addr[7:0]);
            end else if (addr == OFS_ISUM) begin
                kind = RK_ISUM;
            end else if (addr == OFS_ENMASK) begin
                kind = RK_ENMASK;
            end
        end
    end

endmodule

// File: rtl/dmareg_chan.sv
`timescale 1ns/1ps
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cs,
    input  logic              wr_cba,
    input  logic              wr_dbg,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done,
    input  logic              done_irq,
    input  logic              st_pause,
    input  logic              st_held,
    input  logic              st_err,
    output logic [WORD_W-1:0] cs_word,
    output logic [WORD_W-1:0] cba,
    output logic [WORD_W-1:0] dbg,
    output logic              start,
    output logic              irq
);

    chan_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.rst   = 1'b0;
        s_d.abt   = 1'b0;
        s_d.start = 1'b0;
        if (wr_cs) begin
            if (wdata[CSB_END]) s_d.end_f = 1'b0;
            if (wdata[CSB_INT]) s_d.int_f = 1'b0;
            s_d.ctl   = wdata & CS_WMASK;
            s_d.rst   = wdata[CSB_RESET];
            s_d.abt   = wdata[CSB_ABORT];
            s_d.start = wdata[CSB_ACTIVE] & ~s_q.ctl[CSB_ACTIVE];
        end
        if (wr_cba) s_d.cba = wdata;
        if (wr_dbg) s_d.dbg = wdata;
        // Completion from the engine overrides a same-cycle software write
        if (done) begin
            s_d.ctl[CSB_ACTIVE] = 1'b0;
            s_d.end_f           = 1'b1;
            if (done_irq) s_d.int_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        cs_word            = s_q.ctl;
        cs_word[CSB_END]   = s_q.end_f;
        cs_word[CSB_INT]   = s_q.int_f;
        cs_word[CSB_PAUSE] = st_pause;
        cs_word[CSB_HELD]  = st_held;
        cs_word[CSB_ERR]   = st_err;
        cs_word[CSB_ABORT] = s_q.abt;
        cs_word[CSB_RESET] = s_q.rst;
    end

    assign cba   = s_q.cba;
    assign dbg   = s_q.dbg;
    assign start = s_q.start;
    assign irq   = s_q.int_f;

endmodule

// File: rtl/dmareg_front.sv
`timescale 1ns/1ps
module dmareg_front
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CHW   = $clog2(NUM_CH),
    localparam int VW    = NUM_CH * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_win,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [VW-1:0]     eng_info,
    input  logic [VW-1:0]     eng_src,
    input  logic [VW-1:0]     eng_dst,
    input  logic [VW-1:0]     eng_len,
    input  logic [VW-1:0]     eng_stride,
    input  logic [VW-1:0]     eng_next,
    input  logic [NUM_CH-1:0] eng_paused,
    input  logic [NUM_CH-1:0] eng_held,
    input  logic [NUM_CH-1:0] eng_err,
    input  logic [NUM_CH-1:0] eng_done,
    input  logic [NUM_CH-1:0] eng_irq_req,
    output logic [NUM_CH-1:0] ch_start,
    output logic [NUM_CH-1:0] ch_en,
    output logic [VW-1:0]     ch_cba,
    output logic [NUM_CH-1:0] irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t t_d, t_q;

    logic [CHW-1:0]    dec_ch;
    reg_kind_e         dec_kind;
    logic [WORD_W-1:0] cs_a  [NUM_CH];
    logic [WORD_W-1:0] dbg_a [NUM_CH];
    logic [WORD_W-1:0] rd_word;

    dmareg_decode #(.NUM_CH(NUM_CH)) u_dec (
        .win  (bus_win),
        .addr (bus_addr),
        .ch   (dec_ch),
        .kind (dec_kind)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = bus_wr && (dec_ch == CHW'(c));

        dmareg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cs    (sel && (dec_kind == RK_CS)),
            .wr_cba   (sel && (dec_kind == RK_CBA)),
            .wr_dbg   (sel && (dec_kind == RK_DBG)),
            .wdata    (bus_wdata),
            .done     (eng_done[c]),
            .done_irq (eng_irq_req[c]),
            .st_pause (eng_paused[c]),
            .st_held  (eng_held[c]),
            .st_err   (eng_err[c]),
            .cs_word  (cs_a[c]),
            .cba      (ch_cba[c*WORD_W +: WORD_W]),
            .dbg      (dbg_a[c]),
            .start    (ch_start[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        rd_word = '0;
        case (dec_kind)
            RK_CS:     rd_word = cs_a[dec_ch];
            RK_CBA:    rd_word = ch_cba[int'(dec_ch)*WORD_W +: WORD_W];
            RK_INFO:   rd_word = eng_info[int'(dec_ch)*WORD_W +: WORD_W];
            RK_SRC:    rd_word = eng_src[int'(dec_ch)*WORD_W +: WORD_W];
            RK_DST:    rd_word = eng_dst[int'(dec_ch)*WORD_W +: WORD_W];
            RK_LEN:    rd_word = eng_len[int'(dec_ch)*WORD_W +: WORD_W];
            RK_STRIDE: rd_word = eng_stride[int'(dec_ch)*WORD_W +: WORD_W];
            RK_NEXT:   rd_word = eng_next[int'(dec_ch)*WORD_W +: WORD_W];
            RK_DBG:    rd_word = dbg_a[dec_ch];
            RK_ISUM:   rd_word = WORD_W'(irq);
            RK_ENMASK: rd_word = WORD_W'(t_q.en);
            default:   rd_word = '0;
        endcase
    end

    always_comb begin
        t_d = t_q;
        if (bus_rd) t_d.rdata = rd_word;
        if (bus_wr && (dec_kind == RK_ENMASK)) t_d.en = bus_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.en    <= '1;
            t_q.rdata <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign bus_rdata = t_q.rdata;
    assign ch_en     = t_q.en;

endmodule

// File: rtl/dmareg_chk.sv
`timescale 1ns/1ps
module dmareg_chk #(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] eng_done,
    input logic [NUM_CH-1:0] eng_irq_req,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] irq
);

    // R7: an interrupt line only rises after a completion that asked for it
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) & ~$past(eng_done & eng_irq_req)) == '0);

    // R4: an interrupt line only falls after a bus write
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq & $past(irq)) != '0) |-> $past(bus_wr));

    // R6: at most one channel starts per cycle
    p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));

    // R6: a start pulse follows a bus write
    p_start_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> $past(bus_wr));

    // R6: a start pulse lasts one cycle
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |=> ((ch_start & $past(ch_start)) == '0));

    // R11: the enable mask only changes after a write
    p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr) |-> $stable(ch_en));

    // R13: read data only changes after a read strobe
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind dmareg_front dmareg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_rdata   (bus_rdata),
    .eng_done    (eng_done),
    .eng_irq_req (eng_irq_req),
    .ch_start    (ch_start),
    .ch_en       (ch_en),
    .irq         (irq)
);

// File: tb/test_dmareg_front.sv
`timescale 1ns/1ps
module test_dmareg_front;

    localparam int NC = 16;
    localparam int VW = NC * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_win = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [VW-1:0] eng_info, eng_src, eng_dst, eng_len, eng_stride, eng_next;
    logic [NC-1:0] eng_paused = '0, eng_held = '0, eng_err = '0;
    logic [NC-1:0] eng_done = '0, eng_irq_req = '0;
    logic [NC-1:0] ch_start, ch_en, irq;
    logic [VW-1:0] ch_cba;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dmareg_front #(.NUM_CH(NC)) i_dmareg_front (
        .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_info(eng_info), .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
        .eng_stride(eng_stride), .eng_next(eng_next), .eng_paused(eng_paused),
        .eng_held(eng_held), .eng_err(eng_err), .eng_done(eng_done),
        .eng_irq_req(eng_irq_req), .ch_start(ch_start), .ch_en(ch_en),
        .ch_cba(ch_cba), .irq(irq)
    );

    function automatic logic [31:0] pat(input int k, input int c);
        return {8'(k + 1), 8'(c * 3), 16'(16'hBEEF ^ 16'(c * 257))};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic w, input logic [11:0] a, input logic [31:0] d);
        bus_win = w; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic w, input logic [11:0] a, output logic [31:0] d);
        bus_win = w; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cwr(input int c, input logic [7:0] off, input logic [31:0] d);
        if (c == NC - 1) bwr(1'b1, {4'h0, off}, d);
        else             bwr(1'b0, {4'(c), off}, d);
    endtask

    task automatic crd(input int c, input logic [7:0] off, output logic [31:0] d);
        if (c == NC - 1) brd(1'b1, {4'h0, off}, d);
        else             brd(1'b0, {4'(c), off}, d);
    endtask

    task automatic finish_done(input int c, input logic req);
        eng_done[c] = 1'b1; eng_irq_req[c] = req;
        @(negedge clk);
        eng_done = '0; eng_irq_req = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %h expected %h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, hold;
        for (int c = 0; c < NC; c++) begin
            eng_info[c*32 +: 32]   = pat(0, c);
            eng_src[c*32 +: 32]    = pat(1, c);
            eng_dst[c*32 +: 32]    = pat(2, c);
            eng_len[c*32 +: 32]    = pat(3, c);
            eng_stride[c*32 +: 32] = pat(4, c);
            eng_next[c*32 +: 32]   = pat(5, c);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        brd(1'b0, 12'hFF0, v); chk("R1 enable", v, 32'h0000FFFF);
        brd(1'b0, 12'hFE0, v); chk("R1 isum", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        for (int c = 0; c < NC; c++) begin
            crd(c, 8'h00, v); chk($sformatf("R1 cs ch%0d", c), v, 32'h0);
            crd(c, 8'h04, v); chk($sformatf("R1 cba ch%0d", c), v, 32'h0);
        end

        // R2 R9 pointer and debug in both windows
        for (int c = 0; c < NC; c++) begin
            cwr(c, 8'h04, 32'h4000_0000 + 32'(c) * 32'h120);
            cwr(c, 8'h20, ~(32'h0101_0101 * 32'(c)));
        end
        for (int c = 0; c < NC; c++) begin
            crd(c, 8'h04, v); chk($sformatf("R2 R9 cba ch%0d", c), v, 32'h4000_0000 + 32'(c) * 32'h120);
            crd(c, 8'h20, v); chk($sformatf("R2 R9 dbg ch%0d", c), v, ~(32'h0101_0101 * 32'(c)));
            chk($sformatf("R9 ch_cba ch%0d", c), ch_cba[c*32 +: 32], 32'h4000_0000 + 32'(c) * 32'h120);
        end

        // R9 shadow registers, read-only
        for (int c = 0; c < NC; c++) begin
            for (int k = 0; k < 6; k++) begin
                cwr(c, 8'(8 + 4 * k), 32'hFFFF_FFFF);
                crd(c, 8'(8 + 4 * k), v);
                chk($sformatf("R9 shadow ch%0d k%0d", c, k), v, pat(k, c));
            end
        end

        // R3 write mask
        for (int c = 0; c < NC; c++) begin
            cwr(c, 8'h00, 32'h0FFF_FFFE); crd(c, 8'h00, v);
            chk($sformatf("R3 mask a ch%0d", c), v, 32'h00FF_0000);
            cwr(c, 8'h00, 32'h3A5A_A5F0); crd(c, 8'h00, v);
            chk($sformatf("R3 mask b ch%0d", c), v, 32'h305A_0000);
            cwr(c, 8'h00, 32'h0);
        end

        // R6 R7 R4 start, completion, flag clearing
        for (int c = 0; c < NC; c++) begin
            cwr(c, 8'h00, 32'h0000_0001);
            chk($sformatf("R6 start ch%0d", c), 32'(ch_start), 32'(1) << c);
            @(negedge clk);
            chk($sformatf("R6 start width ch%0d", c), 32'(ch_start), 32'h0);
            crd(c, 8'h00, v); chk($sformatf("R3 active ch%0d", c), v, 32'h1);
            cwr(c, 8'h00, 32'h0000_0001);
            chk($sformatf("R6 no restart ch%0d", c), 32'(ch_start), 32'h0);
            finish_done(c, 1'b1);
            chk($sformatf("R7 irq ch%0d", c), 32'(irq), 32'(1) << c);
            crd(c, 8'h00, v); chk($sformatf("R7 cs ch%0d", c), v, 32'h6);
            brd(1'b0, 12'hFE0, v); chk($sformatf("R7 isum ch%0d", c), v, 32'(1) << c);
            cwr(c, 8'h00, 32'h0000_0002);
            crd(c, 8'h00, v); chk($sformatf("R4 end clr ch%0d", c), v, 32'h4);
            chk($sformatf("R4 irq kept ch%0d", c), 32'(irq), 32'(1) << c);
            cwr(c, 8'h00, 32'h0000_0004);
            crd(c, 8'h00, v); chk($sformatf("R4 int clr ch%0d", c), v, 32'h0);
            chk($sformatf("R4 irq low ch%0d", c), 32'(irq), 32'h0);
            brd(1'b0, 12'hFE0, v); chk($sformatf("R4 isum clr ch%0d", c), v, 32'h0);
        end

        // R7 completion without interrupt request; R4 zero write keeps END
        finish_done(7, 1'b0);
        crd(7, 8'h00, v); chk("R7 end only", v, 32'h2);
        chk("R7 no irq", 32'(irq), 32'h0);
        cwr(7, 8'h00, 32'h0);
        crd(7, 8'h00, v); chk("R4 zero write keeps end", v, 32'h2);
        cwr(7, 8'h00, 32'h2);

        // R5 self-clearing request bits
        for (int c = 0; c < NC; c += 5) begin
            cwr(c, 8'h00, 32'hC000_0000);
            crd(c, 8'h00, v); chk($sformatf("R5 first read ch%0d", c), v, 32'hC000_0000);
            crd(c, 8'h00, v); chk($sformatf("R5 second read ch%0d", c), v, 32'h0);
        end

        // R8 live flags, all combinations on two channels
        for (int c = 5; c < NC; c += 10) begin
            for (int m = 0; m < 8; m++) begin
                eng_paused = '0; eng_held = '0; eng_err = '0;
                eng_paused[c] = m[0]; eng_held[c] = m[1]; eng_err[c] = m[2];
                crd(c, 8'h00, v);
                chk($sformatf("R8 flags ch%0d m%0d", c, m), v,
                    (32'(m[0]) << 4) | (32'(m[1]) << 5) | (32'(m[2]) << 8));
            end
        end
        eng_paused = '0; eng_held = '0; eng_err = '0;

        // R10 summary read-only
        finish_done(2, 1'b1);
        finish_done(9, 1'b1);
        bwr(1'b0, 12'hFE0, 32'h0);
        brd(1'b0, 12'hFE0, v); chk("R10 isum write ignored", v, 32'h0000_0204);
        cwr(2, 8'h00, 32'h6);
        cwr(9, 8'h00, 32'h6);
        brd(1'b0, 12'hFE0, v); chk("R10 isum cleared", v, 32'h0);

        // R11 enable mask
        bwr(1'b0, 12'hFF0, 32'hABCD_5A3C);
        chk("R11 ch_en", 32'(ch_en), 32'h0000_5A3C);
        brd(1'b0, 12'hFF0, v); chk("R11 enable read", v, 32'h0000_5A3C);

        // R12 unmapped
        brd(1'b0, 12'hF00, v); chk("R12 read F00", v, 32'h0);
        brd(1'b0, 12'hF04, v); chk("R12 read F04", v, 32'h0);
        brd(1'b0, 12'hFE4, v); chk("R12 read FE4", v, 32'h0);
        brd(1'b0, 12'h324, v); chk("R12 read 324", v, 32'h0);
        brd(1'b0, 12'h106, v); chk("R12 read misaligned", v, 32'h0);
        brd(1'b1, 12'h024, v); chk("R12 read win 24", v, 32'h0);
        bwr(1'b0, 12'hF00, 32'hFFFF_FFFF);
        bwr(1'b0, 12'hFF2, 32'hFFFF_FFFF);
        bwr(1'b0, 12'h124, 32'hFFFF_FFFF);
        bwr(1'b0, 12'h122, 32'hFFFF_FFFF);
        bwr(1'b0, 12'h106, 32'hFFFF_FFFF);
        brd(1'b0, 12'hFF0, v); chk("R12 enable kept", v, 32'h0000_5A3C);
        crd(1, 8'h20, v); chk("R12 dbg kept", v, ~32'h0101_0101);
        crd(1, 8'h04, v); chk("R12 cba kept", v, 32'h4000_0120);

        // R13 read data holds
        crd(3, 8'h04, hold);
        repeat (3) @(negedge clk);
        chk("R13 idle hold", bus_rdata, hold);
        cwr(3, 8'h04, 32'h1234_5678);
        chk("R13 write hold", bus_rdata, hold);
        crd(3, 8'h04, v); chk("R13 new read", v, 32'h1234_5678);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule